// File: doc/BRIEF.md
# Fault-Locating Triple Redundancy Voter

The block takes the outputs of three redundant copies of a module, forms their bitwise majority, and names the copy that disagrees. Three pairwise comparators raise raw disagreement flags for the pairs (1,2), (1,3) and (2,3). A recovery controller outside the block drives three suppress inputs, one per pair, so that once a copy has been declared permanently broken its comparisons stop raising errors and the system runs on the two remaining copies.

All outputs are registered on the rising clock edge and appear one cycle after the inputs that caused them. A synchronous active-high reset clears every output. From the gated pair flags the block decodes a 2-bit location code: 0 for no fault, 1 to 3 for a named copy. A separate flag reports a pattern that no single copy explains. That covers a lone pair flag, which points to the comparator of that pair, and all three flags raised together.

Top module: `tmr_locvote`

## Requirements
- R1: After a clock edge with `rst` high, `voted`, `pair_err`, `any_err`, `bad_mod` and `odd_pat` are all zero.
- R2: One cycle after the inputs, `voted` equals the bitwise majority (a&b)|(a&c)|(b&c) of `mod_a`, `mod_b`, `mod_c`.
- R3: `pair_err` bit 0 reflects a mismatch between copies 1 and 2, bit 1 between copies 1 and 3, and bit 2 between copies 2 and 3. A bit is set when its two copies differ in any bit and its `pair_sup` bit of the same index is 0.
- R4: A `pair_sup` bit at 1 forces the matching `pair_err` bit to 0, whatever the data. With all suppress bits at 0, each `pair_err` bit equals its raw mismatch.
- R5: `any_err` is the OR of the three registered `pair_err` bits.
- R6: When exactly two gated flags are set, `bad_mod` names the copy common to both pairs: {0,1} gives 1, {0,2} gives 2, {1,2} gives 3. In that case `odd_pat` is 0.
- R7: When exactly one gated flag is set, `odd_pat` is 1 and `bad_mod` is 0, marking a comparator fault.
- R8: When all three gated flags are set, `odd_pat` is 1 and `bad_mod` is 0. When none is set, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mod_a | input | W | Output of copy 1 |
| mod_b | input | W | Output of copy 2 |
| mod_c | input | W | Output of copy 3 |
| pair_sup | input | 3 | Suppress bits for pairs 12, 13, 23 |
| voted | output | W | Registered bitwise majority |
| pair_err | output | 3 | Registered gated pair flags 12, 13, 23 |
| any_err | output | 1 | Registered OR of gated flags |
| bad_mod | output | 2 | Registered faulty copy code, 0 = none |
| odd_pat | output | 1 | Registered comparator-fault or undecodable flag |

## Verification
Masking and location decoding act in the same cycle. A suppress bit changes the flag pattern that the decoder sees, so a copy can be named from two raw flags, or a lone surviving flag can be reported as a comparator fault. The bench holds one copy wrong and steps through suppress combinations. For each combination it predicts the gated flags, the location code and the odd-pattern flag from the requirements, and checks them one cycle later. The bench also checks that the voted data never depends on the suppress bits.

// File: rtl/tmr_locvote.sv
module tmr_locvote #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mod_a,
  input  logic [W-1:0] mod_b,
  input  logic [W-1:0] mod_c,
  input  logic [2:0]   pair_sup,
  output logic [W-1:0] voted,
  output logic [2:0]   pair_err,
  output logic         any_err,
  output logic [1:0]   bad_mod,
  output logic         odd_pat
);

  logic [2:0] raw, gated;
  logic [1:0] loc;
  logic       odd;

  assign raw[0] = |(mod_a ^ mod_b);
  assign raw[1] = |(mod_a ^ mod_c);
  assign raw[2] = |(mod_b ^ mod_c);
  assign gated  = raw & ~pair_sup;

  always_comb begin
    loc = 2'd0;
    odd = 1'b0;
    unique case (gated)
      3'b000: ;
      3'b011: loc = 2'd1;
      3'b101: loc = 2'd2;
      3'b110: loc = 2'd3;
      default: odd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      voted    <= '0;
      pair_err <= '0;
      any_err  <= 1'b0;
      bad_mod  <= 2'd0;
      odd_pat  <= 1'b0;
    end else begin
      voted    <= (mod_a & mod_b) | (mod_a & mod_c) | (mod_b & mod_c);
      pair_err <= gated;
      any_err  <= |gated;
      bad_mod  <= loc;
      odd_pat  <= odd;
    end
  end

endmodule

module tmr_locvote_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] mod_a,
  input logic [W-1:0] mod_b,
  input logic [W-1:0] mod_c,
  input logic [2:0]   pair_sup,
  input logic [W-1:0] voted,
  input logic [2:0]   pair_err,
  input logic         any_err,
  input logic [1:0]   bad_mod,
  input logic         odd_pat
);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pair_err == 3'b000 && !any_err && bad_mod == 2'd0 && !odd_pat)); // R1
  AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (rst) any_err == (|pair_err)); // R5
  AST_SUP_BLOCKS: assert property (@(posedge clk) disable iff (rst) pair_sup[0] |=> !pair_err[0]); // R4
  AST_MOD_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst) (bad_mod != 2'd0) |-> ($countones(pair_err) == 2 && !odd_pat)); // R6
  AST_LONE_FLAG_ODD: assert property (@(posedge clk) disable iff (rst) ($countones(pair_err) == 1) |-> (odd_pat && bad_mod == 2'd0)); // R7
  AST_QUIET_CLEAN: assert property (@(posedge clk) disable iff (rst) (pair_err == 3'b000) |-> (!odd_pat && bad_mod == 2'd0)); // R8
  AST_AGREE_VOTE: assert property (@(posedge clk) disable iff (rst) (mod_a == mod_b) |=> (voted == $past(mod_a))); // R2

endmodule

bind tmr_locvote tmr_locvote_chk #(.W(W)) u_chk (.*);

// File: tb/test_tmr_locvote.sv
module test_tmr_locvote;
  localparam int W = 8;
  logic clk = 0, rst = 1;
  logic [W-1:0] a = 0, b = 0, c = 0;
  logic [2:0] sup = 0;
  logic [W-1:0] voted;
  logic [2:0] pair_err;
  logic any_err, odd_pat;
  logic [1:0] bad_mod;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tmr_locvote #(.W(W)) i_tmr_locvote (.clk(clk), .rst(rst), .mod_a(a), .mod_b(b), .mod_c(c),
    .pair_sup(sup), .voted(voted), .pair_err(pair_err), .any_err(any_err),
    .bad_mod(bad_mod), .odd_pat(odd_pat));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] xa, xb, xc, logic [2:0] xs);
    a = xa; b = xb; c = xc; sup = xs;
    @(posedge clk); #1;
  endtask

  task automatic expect_all(logic [W-1:0] xa, xb, xc, logic [2:0] xs);
    logic [2:0] g;
    logic [1:0] m;
    logic o;
    g[0] = (xa != xb) && !xs[0];
    g[1] = (xa != xc) && !xs[1];
    g[2] = (xb != xc) && !xs[2];
    m = 0; o = 0;
    case (g)
      3'b000: ;
      3'b011: m = 1;
      3'b101: m = 2;
      3'b110: m = 3;
      default: o = 1;
    endcase
    apply(xa, xb, xc, xs);
    chk("R2 voted", voted, (xa & xb) | (xa & xc) | (xb & xc));
    chk("R3 R4 pair_err", pair_err, g);
    chk("R5 any_err", any_err, |g);
    chk("R6 R7 R8 bad_mod", bad_mod, m);
    chk("R7 R8 odd_pat", odd_pat, o);
  endtask

  task automatic t_reset;
    a = 8'h0F; b = 8'hF0; c = 8'h33; rst = 1;
    @(posedge clk); #1;
    chk("R1 voted", voted, 0);
    chk("R1 pair_err", pair_err, 0);
    chk("R1 any_err", any_err, 0);
    chk("R1 bad_mod", bad_mod, 0);
    chk("R1 odd_pat", odd_pat, 0);
    rst = 0;
  endtask

  task automatic t_single_copy;
    expect_all(8'hA5, 8'hA5, 8'hA5, 0);
    expect_all(8'h00, 8'hA5, 8'hA5, 0); // R6 copy 1
    expect_all(8'hA5, 8'h01, 8'hA5, 0); // R6 copy 2
    expect_all(8'hA5, 8'hA5, 8'h80, 0); // R6 copy 3
  endtask

  task automatic t_multi;
    expect_all(8'hFF, 8'h0F, 8'h3C, 0); // R8 all three
    expect_all(8'h12, 8'h34, 8'h56, 0);
  endtask

  task automatic t_mask;
    for (int s = 0; s < 8; s++) begin
      expect_all(8'h55, 8'h55, 8'hAA, s[2:0]); // R4 R7 masking copy 3
      expect_all(8'h3C, 8'hC3, 8'h3C, s[2:0]);
    end
    expect_all(8'h01, 8'h02, 8'h04, 3'b111);
    chk("R4 pair_err masked", pair_err, 0);
  endtask

  initial begin
    #1;
    t_reset;
    t_single_copy;
    t_multi;
    t_mask;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule